// File: doc/BRIEF.md
# Power-On Configuration Loader Sequencer

This block runs once for every power-on request. It fills a set of configuration shadow registers, decides whether the stored configuration may be trusted, and then either grants the power-up sequence or holds the device off. The lower configuration section always comes from the on-chip one-time-programmable (OTP) store. The upper section comes from one of two places. A mode strap, sampled when the request arrives, selects either the OTP store or an external serial EEPROM. The EEPROM is reached through a byte-read handshake toward an I2C master.

A reload-enable bit decides whether the upper section is fetched again or the current upper shadow is kept. That bit can be written only after software writes a key to a security register. Two checks gate start-up:
- In development mode, the EEPROM signature word must be correct.
- The customer identifier in the lower section must be non-zero.

Newly fetched upper data is committed to the shadow only when start-up is granted. An error code tells the caller why start-up was held off.

Top module: `boot_cfg_seq`

## Requirements
- R1: `dev_strap` is sampled when `pwr_req` is accepted in idle. High selects the EEPROM as the upper-section source. Low selects OTP. Later changes to `dev_strap` have no effect on the running sequence.
- R2: On every accepted request, lower words 0..3 are read from OTP addresses 0..3 into `lo_shadow` (word k at bits 16k+15:16k), whatever the reload setting and the outcome.
- R3: When reload is enabled, the four upper words are fetched. From OTP they come from addresses 4..7. From the EEPROM they come from byte addresses 0..7, the first byte of each pair being the high byte. When reload is disabled and the strap is low, no upper data is read.
- R4: In development mode, upper word 0 (EEPROM bytes 0 and 1) must equal 16'hA596, otherwise the result is hold-off with `err_code`=1. This check also runs when reload is disabled; only bytes 0 and 1 are then read. In OTP mode the signature is not checked.
- R5: If lower word 0 (the customer identifier) is zero, the result is hold-off with `err_code`=2. This applies with reload enabled or disabled.
- R6: Either of two events ends the sequence at once with hold-off and `err_code`=3, and no further EEPROM requests are made:
  - a NACK on an EEPROM byte read;
  - no response within 32 cycles.
- R7: Error priority is 3 over 1 over 2. A granted start-up reports `err_code`=0.
- R8: `reload_en` is bit 15 of the control register (`reg_sel`=0) and resets to 1. A write to it changes it only while the key lock is open.
- R9: A write of 16'hC3A5 to the security register (`reg_sel`=1) opens the lock. Any other value written there closes it. Reset closes it. `key_locked` shows the lock state.
- R10: `hi_shadow` changes only together with a granted start-up that had reload enabled. A failed attempt leaves it unchanged.
- R11: Every EEPROM byte request carries device byte 8'hA1. `ee_addr` is held stable while a request waits for a response.
- R12: The end of a sequence is marked by a one-cycle `done` pulse. At that pulse exactly one of `grant` and `hold_off` is high. Both hold their values until the next accepted request. A `pwr_req` while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pwr_req | input | 1 | Power-on request pulse |
| dev_strap | input | 1 | Source strap: 1 = EEPROM, 0 = OTP |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control register, 1 = security register |
| reg_wdata | input | 16 | Register write data |
| reload_en | output | 1 | Current reload-enable bit |
| key_locked | output | 1 | 1 while the reload bit is write-protected |
| otp_rd | output | 1 | OTP read strobe; data is returned the next cycle |
| otp_addr | output | 3 | OTP word address |
| otp_rdata | input | 16 | OTP read data |
| ee_req | output | 1 | EEPROM byte-read request, held until a response |
| ee_dev | output | 8 | Device address byte |
| ee_addr | output | 8 | EEPROM byte address |
| ee_ack | input | 1 | Byte-read complete; `ee_rdata` valid |
| ee_nack | input | 1 | Device did not acknowledge |
| ee_rdata | input | 8 | Byte read data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| grant | output | 1 | Start-up granted |
| hold_off | output | 1 | Start-up refused; device stays off |
| err_code | output | 2 | 0 ok, 1 bad signature, 2 zero customer ID, 3 device missing |
| lo_shadow | output | 64 | Lower configuration shadow |
| hi_shadow | output | 64 | Upper configuration shadow |

## Verification
The assertions check these rules on every cycle:
- the grant and hold-off outcomes never appear together;
- every `done` pulse carries exactly one outcome, with an error code that matches it;
- the two memory ports are never active at once;
- `ee_addr` stays stable while a request is pending;
- the reload bit does not move under a closed lock;
- a foreign security write relocks;
- the upper shadow changes only with a grant.

Other behaviours need scenarios and only the bench can show them:
- the strap choosing the source;
- the byte-count difference between reload and signature-only reads;
- the big-endian byte assembly;
- the error priority when several faults combine;
- the 32-cycle missing-device timeout;
- a request arriving while busy being dropped.

// File: rtl/boot_cfg_seq.sv
module boot_cfg_seq #(
  parameter int          LO_WORDS    = 4,
  parameter int          HI_WORDS    = 4,
  parameter int          TIMEOUT_CYC = 32,
  parameter int          CUST_IDX    = 0,
  parameter logic [15:0] UNLOCK_KEY  = 16'hC3A5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pwr_req,
  input  logic        dev_strap,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [15:0] reg_wdata,
  output logic        reload_en,
  output logic        key_locked,
  output logic        otp_rd,
  output logic [2:0]  otp_addr,
  input  logic [15:0] otp_rdata,
  output logic        ee_req,
  output logic [7:0]  ee_dev,
  output logic [7:0]  ee_addr,
  input  logic        ee_ack,
  input  logic        ee_nack,
  input  logic [7:0]  ee_rdata,
  output logic        busy,
  output logic        done,
  output logic        grant,
  output logic        hold_off,
  output logic [1:0]  err_code,
  output logic [16*LO_WORDS-1:0] lo_shadow,
  output logic [16*HI_WORDS-1:0] hi_shadow
);
  localparam int OTP_AW   = $clog2(LO_WORDS + HI_WORDS);
  localparam int EE_BYTES = 2 * HI_WORDS;
  localparam int LW       = (LO_WORDS > 1) ? $clog2(LO_WORDS) : 1;
  localparam int HW       = (HI_WORDS > 1) ? $clog2(HI_WORDS) : 1;
  localparam int IW       = $clog2(EE_BYTES) + 1;
  localparam int TW       = $clog2(TIMEOUT_CYC + 1);
  localparam logic [15:0] SIG     = 16'hA596;
  localparam logic [7:0]  DEV_RD  = 8'hA1;
  localparam logic [1:0]  E_NONE  = 2'd0;
  localparam logic [1:0]  E_SIG   = 2'd1;
  localparam logic [1:0]  E_CUST  = 2'd2;
  localparam logic [1:0]  E_DEV   = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_LO, S_HI_OTP, S_EE, S_EVAL} st_t;

  st_t            st;
  logic           ph, dev_q, rel_q;
  logic [IW-1:0]  idx;
  logic [TW-1:0]  tmo;
  logic [15:0]    lo_mem [LO_WORDS];
  logic [15:0]    stage  [HI_WORDS];
  logic [15:0]    hi_mem [HI_WORDS];
  logic           reload_q, locked_q, done_q, grant_q, hold_q;
  logic [1:0]     err_q;

  wire            tmo_hit  = (tmo == TW'(TIMEOUT_CYC - 1));
  wire [IW-1:0]   ee_last  = rel_q ? IW'(EE_BYTES - 1) : IW'(1);
  wire            lo_last  = (idx == IW'(LO_WORDS - 1));
  wire            hi_last  = (idx == IW'(HI_WORDS - 1));

  assign reload_en  = reload_q;
  assign key_locked = locked_q;
  assign busy       = (st != S_IDLE);
  assign done       = done_q;
  assign grant      = grant_q;
  assign hold_off   = hold_q;
  assign err_code   = err_q;
  assign otp_rd     = (st == S_LO || st == S_HI_OTP) && !ph;
  assign otp_addr   = (st == S_HI_OTP) ? 3'(OTP_AW'(LO_WORDS) + OTP_AW'(idx)) : 3'(OTP_AW'(idx));
  assign ee_req     = (st == S_EE);
  assign ee_dev     = DEV_RD;
  assign ee_addr    = 8'(idx);

  genvar g;
  generate
    for (g = 0; g < LO_WORDS; g++) begin : g_lo
      assign lo_shadow[16*g +: 16] = lo_mem[g];
    end
    for (g = 0; g < HI_WORDS; g++) begin : g_hi
      assign hi_shadow[16*g +: 16] = hi_mem[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= 1'b1;
      locked_q <= 1'b1;
    end else if (reg_wr) begin
      if (reg_sel) locked_q <= (reg_wdata != UNLOCK_KEY);
      else if (!locked_q) reload_q <= reg_wdata[15];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ph <= 1'b0;
      idx <= '0;
      tmo <= '0;
      dev_q <= 1'b0;
      rel_q <= 1'b0;
      done_q <= 1'b0;
      grant_q <= 1'b0;
      hold_q <= 1'b0;
      err_q <= E_NONE;
      for (int k = 0; k < LO_WORDS; k++) lo_mem[k] <= '0;
      for (int k = 0; k < HI_WORDS; k++) begin
        stage[k]  <= '0;
        hi_mem[k] <= '0;
      end
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (pwr_req) begin
          dev_q   <= dev_strap;
          rel_q   <= reload_q;
          idx     <= '0;
          ph      <= 1'b0;
          grant_q <= 1'b0;
          hold_q  <= 1'b0;
          err_q   <= E_NONE;
          st      <= S_LO;
        end
        S_LO: begin
          ph <= !ph;
          if (ph) begin
            lo_mem[idx[LW-1:0]] <= otp_rdata;
            if (lo_last) begin
              idx <= '0;
              tmo <= '0;
              st  <= dev_q ? S_EE : (rel_q ? S_HI_OTP : S_EVAL);
            end else idx <= idx + 1'b1;
          end
        end
        S_HI_OTP: begin
          ph <= !ph;
          if (ph) begin
            stage[idx[HW-1:0]] <= otp_rdata;
            if (hi_last) st <= S_EVAL;
            else idx <= idx + 1'b1;
          end
        end
        S_EE: begin
          if (ee_ack) begin
            if (!idx[0]) stage[idx[HW:1]][15:8] <= ee_rdata;
            else         stage[idx[HW:1]][7:0]  <= ee_rdata;
            tmo <= '0;
            if (idx == ee_last) st <= S_EVAL;
            else idx <= idx + 1'b1;
          end else if (ee_nack || tmo_hit) begin
            hold_q <= 1'b1;
            err_q  <= E_DEV;
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else tmo <= tmo + 1'b1;
        end
        S_EVAL: begin
          done_q <= 1'b1;
          st     <= S_IDLE;
          if (dev_q && stage[0] != SIG) begin
            hold_q <= 1'b1;
            err_q  <= E_SIG;
          end else if (lo_mem[CUST_IDX] == 16'h0000) begin
            hold_q <= 1'b1;
            err_q  <= E_CUST;
          end else begin
            grant_q <= 1'b1;
            if (rel_q)
              for (int k = 0; k < HI_WORDS; k++) hi_mem[k] <= stage[k];
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R12
  outcome_mutex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && hold_off));
  // R12
  done_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (grant ^ hold_off));
  // R7
  grant_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && grant) |-> (err_code == E_NONE));
  // R6
  hold_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hold_off) |-> (err_code != E_NONE));
  // R1
  src_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(otp_rd && ee_req));
  // R11
  ee_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_req && !ee_ack && !ee_nack && !tmo_hit) |=> (ee_req && $stable(ee_addr)));
  // R8
  lock_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel && key_locked) |=> $stable(reload_en));
  // R9
  relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel && reg_wdata != UNLOCK_KEY) |=> key_locked);
  // R10
  shadow_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hi_shadow) |-> (done && grant));
endmodule

// File: tb/sim_boot_cfg_seq.sv
module sim_boot_cfg_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;
  // {dev, rel, mode[1:0], cust_zero, sig_bad, exp_grant, exp_err[1:0]}
  localparam logic [8:0] VEC [NV] = '{
    {1'b0,1'b1,2'd0,1'b0,1'b0,1'b1,2'd0},
    {1'b1,1'b1,2'd0,1'b0,1'b0,1'b1,2'd0},
    {1'b0,1'b0,2'd0,1'b0,1'b0,1'b1,2'd0},
    {1'b1,1'b0,2'd0,1'b0,1'b0,1'b1,2'd0},
    {1'b1,1'b1,2'd0,1'b0,1'b1,1'b0,2'd1},
    {1'b1,1'b0,2'd0,1'b0,1'b1,1'b0,2'd1},
    {1'b0,1'b1,2'd0,1'b1,1'b0,1'b0,2'd2},
    {1'b0,1'b0,2'd0,1'b1,1'b0,1'b0,2'd2},
    {1'b1,1'b1,2'd1,1'b0,1'b0,1'b0,2'd3},
    {1'b1,1'b1,2'd2,1'b0,1'b0,1'b0,2'd3},
    {1'b1,1'b1,2'd0,1'b1,1'b1,1'b0,2'd1},
    {1'b1,1'b1,2'd1,1'b1,1'b1,1'b0,2'd3},
    {1'b0,1'b1,2'd0,1'b0,1'b1,1'b1,2'd0}
  };

  logic clk = 0, rst_n = 0, pwr_req = 0, dev_strap = 0;
  logic reg_wr = 0, reg_sel = 0;
  logic [15:0] reg_wdata = '0;
  logic reload_en, key_locked, otp_rd, ee_req, ee_ack = 0, ee_nack = 0;
  logic [2:0] otp_addr;
  logic [15:0] otp_rdata = '0;
  logic [7:0] ee_dev, ee_addr, ee_rdata = '0;
  logic busy, done, grant, hold_off;
  logic [1:0] err_code;
  logic [63:0] lo_shadow, hi_shadow, exp_lo, exp_hi;
  logic [15:0] otp_mem [8];
  logic [7:0]  ee_mem [8];
  int checks = 0, errors = 0, ee_mode = 0, ee_cnt = 0, acks = 0, dev_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_cfg_seq u0 (.*);

  always @(posedge clk) begin
    if (otp_rd) otp_rdata <= otp_mem[otp_addr];
  end

  always @(posedge clk) begin
    ee_ack  <= 1'b0;
    ee_nack <= 1'b0;
    if (ee_req && !ee_ack && !ee_nack) begin
      if (ee_dev != 8'hA1) dev_bad++;
      if (ee_mode != 1 && ee_cnt == 2) begin
        ee_cnt <= 0;
        if (ee_mode == 0) begin
          ee_ack   <= 1'b1;
          ee_rdata <= ee_mem[ee_addr[2:0]];
          acks++;
        end else ee_nack <= 1'b1;
      end else ee_cnt <= ee_cnt + 1;
    end else ee_cnt <= 0;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic sel, input logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic run_req(output int cyc);
    @(negedge clk); pwr_req = 1;
    @(negedge clk); pwr_req = 0; cyc = 1;
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cyc, dones;
    for (int k = 0; k < 8; k++) begin otp_mem[k] = 16'h0101 * (k + 1); ee_mem[k] = 8'h00; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(reload_en == 1, "R8 reset reload_en", 64'(reload_en), 64'd1);
    chk(key_locked == 1, "R9 reset locked", 64'(key_locked), 64'd1);
    chk(!grant && !hold_off && !busy && err_code == 0, "R12 reset outputs",
        64'({grant, hold_off, busy, err_code}), 64'd0);
    chk(hi_shadow == 0, "R10 reset hi_shadow", hi_shadow, 64'd0);

    wr_reg(0, 16'h0000);
    chk(reload_en == 1, "R8 locked write ignored", 64'(reload_en), 64'd1);
    wr_reg(1, 16'hC3A5);
    chk(key_locked == 0, "R9 unlock", 64'(key_locked), 64'd0);
    wr_reg(0, 16'h0000);
    chk(reload_en == 0, "R8 unlocked write", 64'(reload_en), 64'd0);
    wr_reg(1, 16'hC3A4);
    chk(key_locked == 1, "R9 bad key relocks", 64'(key_locked), 64'd1);
    wr_reg(0, 16'h8000);
    chk(reload_en == 0, "R8 write after relock ignored", 64'(reload_en), 64'd0);

    exp_hi = '0;
    for (int i = 0; i < NV; i++) begin
      logic [8:0] v;
      v = VEC[i];
      for (int k = 0; k < 8; k++) otp_mem[k] = 16'h1100 * (i + 1) + 16'(k) + 16'h0010;
      if (v[4]) otp_mem[0] = 16'h0000;
      otp_mem[4] = 16'h5A00 + 16'(i);
      ee_mem[0] = 8'hA5;
      ee_mem[1] = v[3] ? 8'h97 : 8'h96;
      for (int b = 2; b < 8; b++) ee_mem[b] = 8'(16 * i + b);
      ee_mode = int'(v[6:5]);
      dev_strap = v[8];
      wr_reg(1, 16'hC3A5);
      wr_reg(0, {v[7], 15'h0});
      wr_reg(1, 16'h0000);
      acks = 0; dev_bad = 0;
      run_req(cyc);
      for (int k = 0; k < 4; k++) exp_lo[16*k +: 16] = otp_mem[k];
      if (v[2] && v[7])
        for (int k = 0; k < 4; k++)
          exp_hi[16*k +: 16] = v[8] ? {ee_mem[2*k], ee_mem[2*k+1]} : otp_mem[4+k];
      chk(done && grant == v[2], $sformatf("R12 vec%0d grant", i), 64'(grant), 64'(v[2]));
      chk(hold_off == !v[2], $sformatf("R12 vec%0d hold_off", i), 64'(hold_off), 64'(!v[2]));
      chk(err_code == v[1:0], $sformatf("R7 vec%0d err (R4 R5 R6)", i), 64'(err_code), 64'(v[1:0]));
      chk(lo_shadow == exp_lo, $sformatf("R2 vec%0d lo", i), lo_shadow, exp_lo);
      chk(hi_shadow == exp_hi, $sformatf("R3 R10 vec%0d hi", i), hi_shadow, exp_hi);
      chk(acks == ((v[8] && ee_mode == 0) ? (v[7] ? 8 : 2) : 0),
          $sformatf("R1 R4 vec%0d ee bytes", i), 64'(acks),
          64'((v[8] && ee_mode == 0) ? (v[7] ? 8 : 2) : 0));
      chk(dev_bad == 0, $sformatf("R11 vec%0d device byte", i), 64'(dev_bad), 64'd0);
      @(negedge clk);
      chk(grant == v[2] && !done, $sformatf("R12 vec%0d result held", i),
          64'({grant, done}), 64'({v[2], 1'b0}));
    end

    ee_mode = 0; dev_strap = 1; acks = 0; dones = 0;
    ee_mem[1] = 8'h96;
    for (int k = 0; k < 8; k++) otp_mem[k] = 16'h2222;
    wr_reg(1, 16'hC3A5);
    wr_reg(0, 16'h8000);
    @(negedge clk); pwr_req = 1;
    @(negedge clk); pwr_req = 0;
    repeat (4) @(negedge clk);
    dev_strap = 0; pwr_req = 1;
    @(negedge clk); pwr_req = 0;
    for (int c = 0; c < 150; c++) begin
      if (done) dones++;
      @(negedge clk);
    end
    chk(dones == 1, "R12 request while busy ignored", 64'(dones), 64'd1);
    chk(acks == 8, "R1 strap sampled at request", 64'(acks), 64'd8);
    chk(grant == 1, "R1 grant after strap change", 64'(grant), 64'd1);

    ee_mode = 1; dev_strap = 1;
    run_req(cyc);
    chk(err_code == 3 && hold_off, "R6 timeout error", 64'(err_code), 64'd3);
    chk(cyc >= 40 && cyc <= 48, "R6 timeout length", 64'(cyc), 64'd42);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule